// File: doc/BRIEF.md
# Selectable Serial Test Pattern Source

This block produces a serial test stream for one tributary channel, one bit for each cycle in which its bit enable is high. The stream is one of four patterns: two maximal-length pseudorandom sequences (15-stage and 20-stage), a square wave of alternating zeros and ones, or a constant one. Each channel uses its own copy of the block, and copies run side by side at independent rates because each has its own bit enable.

The pattern can fill every bit. In framed mode it fills only the positions that an external slot strobe marks as payload. Overhead positions carry a zero and leave the pattern where it was, so the payload content is the same whatever the framing density. Software can ask for one deliberate bit error. The request waits and inverts exactly one later payload bit.

Each output bit comes with a valid strobe that is registered one cycle after the bit enable. The framing structure, routing and line coding are built elsewhere.

Top module: `tpat_gen`

## Requirements
- R1: After reset, `tx_valid` and `tx_bit` are 0. Both pseudorandom registers hold the all-ones seed, the square wave is at phase 0, and the remembered selection is 0.
- R2: `tx_valid` is 1 in exactly the cycle after a cycle with `bit_en` high. `tx_bit` is 0 whenever `tx_valid` is 0.
- R3: `pat_sel` encoding: 0 = 15-stage sequence, 1 = 20-stage sequence, 2 = alternating, 3 = all ones.
- R4: 15-stage sequence. The state s[14:0] starts at all ones. The emitted bit is s[14], and the next state is {s[13:0], s[14]^s[13]}.
- R5: 20-stage sequence. The state s[19:0] starts at all ones. The emitted bit is s[19], and the next state is {s[18:0], s[19]^s[16]}.
- R6: The alternating pattern emits 0 first after a seed, then toggles on every payload bit.
- R7: The all-ones pattern emits 1 on every payload bit.
- R8: With `framed_mode`=1, a bit is payload only when `slot_payload`=1. An overhead bit is emitted as 0 with `tx_valid` high, and the pattern does not advance.
- R9: With `framed_mode`=0, every enabled bit is payload and `slot_payload` has no effect.
- R10: A pulse on `err_inject` inverts the first payload bit emitted with `bit_en` in a later cycle. Several requests before that bit give one error only, and overhead bits are never inverted.
- R11: When `pat_sel` differs from the selection used at the previous enabled bit, the next enabled bit restarts the chosen pattern from its seed.
- R12: Cycles without `bit_en` leave all pattern state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Produce one bit this cycle |
| pat_sel | input | 2 | Pattern choice (R3 encoding) |
| framed_mode | input | 1 | 1 = payload-only gating by `slot_payload` |
| slot_payload | input | 1 | Marks the current bit position as payload |
| err_inject | input | 1 | One-cycle request for a single bit error |
| tx_bit | output | 1 | Serial test bit |
| tx_valid | output | 1 | `tx_bit` is valid this cycle |

## Verification
Each pattern runs unframed for hundreds of bits with idle gaps in between. A wrong tap, a wrong output stage or advancing while idle breaks the sequence computed in the bench from the recurrences.

The same patterns then run in framed mode with a sparse payload map. This separates "advance only on payload" from "advance on every enable". Unframed runs with a toggling slot strobe show that the strobe is ignored when framing is off.

Error requests are placed on payload bits, on overhead bits, during idle gaps and back to back. These cases show whether exactly one later payload bit is inverted. Switching the selection back and forth shows that each pattern restarts from its seed.

// File: rtl/tpat_pkg.sv
package tpat_pkg;

    typedef enum logic [1:0] {
        PAT_PRBS15 = 2'd0,
        PAT_PRBS20 = 2'd1,
        PAT_ALT    = 2'd2,
        PAT_ONES   = 2'd3
    } pat_t;

    typedef struct packed {
        logic       valid;
        logic       bit_v;
        logic [1:0] sel;
        logic       alt;
    } gen_state_t;

endpackage

// File: rtl/tpat_lfsr.sv
// Fibonacci shift register: emits the top stage, feeds back top ^ tap.
module tpat_lfsr #(
    parameter int WIDTH = 15,
    parameter int TAP   = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic reseed,
    output logic out_bit
);
    localparam logic [WIDTH-1:0] SEED = '1;

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;
    logic [WIDTH-1:0] eff;

    always_comb begin
        eff     = reseed ? SEED : state_q;
        out_bit = eff[WIDTH-1];
        state_d = state_q;
        if (step) begin
            state_d = {eff[WIDTH-2:0], eff[WIDTH-1] ^ eff[TAP-1]};
        end else if (reseed) begin
            state_d = SEED;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEED;
        else        state_q <= state_d;
    end

    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);                                                // R4
    AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !reseed) |=> $stable(state_q));                      // R12
    AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !reseed) |=> state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])); // R5
endmodule

// File: rtl/tpat_err_latch.sv
// Holds one pending error request until a payload bit consumes it.
module tpat_err_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic inject,
    input  logic consume,
    output logic pending
);
    logic pend_q;
    logic pend_d;

    always_comb begin
        pend_d = (pend_q && !consume) || inject;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    assign pending = pend_q;

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        inject |=> pend_q);                                            // R10
    AST_ERR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        consume |=> (!pend_q || $past(inject)));                       // R10
endmodule

// File: rtl/tpat_gen.sv
module tpat_gen
    import tpat_pkg::*;
#(
    parameter int P15_WIDTH = 15,
    parameter int P15_TAP   = 14,
    parameter int P20_WIDTH = 20,
    parameter int P20_TAP   = 17
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic [1:0] pat_sel,
    input  logic       framed_mode,
    input  logic       slot_payload,
    input  logic       err_inject,
    output logic       tx_bit,
    output logic       tx_valid
);
    gen_state_t st_q, st_d;
    pat_t       sel_now;
    logic       sel_chg, reseed, payload, emit;
    logic       alt_eff, pat_bit;
    logic       b15, b20, step15, step20, err_pend;

    tpat_lfsr #(.WIDTH(P15_WIDTH), .TAP(P15_TAP)) i_lfsr15 (
        .clk(clk), .rst_n(rst_n), .step(step15), .reseed(reseed), .out_bit(b15));

    tpat_lfsr #(.WIDTH(P20_WIDTH), .TAP(P20_TAP)) i_lfsr20 (
        .clk(clk), .rst_n(rst_n), .step(step20), .reseed(reseed), .out_bit(b20));

    tpat_err_latch i_err (
        .clk(clk), .rst_n(rst_n), .inject(err_inject), .consume(emit), .pending(err_pend));

    always_comb begin
        sel_now = pat_t'(pat_sel);
        sel_chg = (pat_sel != st_q.sel);
        reseed  = bit_en && sel_chg;
        payload = !framed_mode || slot_payload;
        emit    = bit_en && payload;
        alt_eff = sel_chg ? 1'b0 : st_q.alt;
        step15  = emit && (sel_now == PAT_PRBS15);
        step20  = emit && (sel_now == PAT_PRBS20);

        case (sel_now)
            PAT_PRBS15: pat_bit = b15;
            PAT_PRBS20: pat_bit = b20;
            PAT_ALT:    pat_bit = alt_eff;
            default:    pat_bit = 1'b1;
        endcase

        st_d       = st_q;
        st_d.valid = bit_en;
        st_d.bit_v = emit ? (pat_bit ^ err_pend) : 1'b0;
        if (bit_en) st_d.sel = pat_sel;
        if (reseed) st_d.alt = 1'b0;
        if (emit && sel_now == PAT_ALT) st_d.alt = ~alt_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{valid: 1'b0, bit_v: 1'b0, sel: 2'd0, alt: 1'b0};
        else        st_q <= st_d;
    end

    assign tx_bit   = st_q.bit_v;
    assign tx_valid = st_q.valid;

    AST_VALID_TRACKS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en |=> tx_valid);                                          // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> (!tx_valid && !tx_bit));                           // R2
    AST_OVERHEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && framed_mode && !slot_payload) |=> !tx_bit);         // R8
    AST_ONES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && payload && pat_sel == 2'd3 && !err_pend) |=> tx_bit); // R7
endmodule

// File: tb/test_tpat_gen.sv
`timescale 1ns/1ps
module test_tpat_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] pat_sel = 2'd0;
    logic       framed_mode = 1'b0;
    logic       slot_payload = 1'b0;
    logic       err_inject = 1'b0;
    logic       tx_bit, tx_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [14:0] m15  = '1;
    logic [19:0] m20  = '1;
    logic        malt = 1'b0;
    logic [1:0]  msel = 2'd0;
    logic        mpend = 1'b0;

    always #4 clk = ~clk;

    tpat_gen i_tpat_gen (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pat_sel(pat_sel),
        .framed_mode(framed_mode), .slot_payload(slot_payload),
        .err_inject(err_inject), .tx_bit(tx_bit), .tx_valid(tx_valid));

    task automatic check(input string req, input logic v, input logic b,
                         input logic ev, input logic eb);
        checks++;
        if (v !== ev || b !== eb) begin
            fails++;
            $display("FAIL %s: tx_valid=%0b tx_bit=%0b expected tx_valid=%0b tx_bit=%0b",
                     req, v, b, ev, eb);
        end
    endtask

    task automatic set_framed(input logic f);
        @(negedge clk);
        framed_mode = f;
    endtask

    task automatic apply(input logic en, input logic pay, input logic inj,
                         input logic [1:0] sel, input string req);
        logic exp_b;
        logic b;
        @(negedge clk);
        bit_en = en; slot_payload = pay; err_inject = inj; pat_sel = sel;
        exp_b = 1'b0;
        if (en) begin
            if (sel != msel) begin
                m15 = '1; m20 = '1; malt = 1'b0;
            end
            msel = sel;
            if (!framed_mode || pay) begin
                case (sel)
                    2'd0: begin b = m15[14]; m15 = {m15[13:0], m15[14] ^ m15[13]}; end
                    2'd1: begin b = m20[19]; m20 = {m20[18:0], m20[19] ^ m20[16]}; end
                    2'd2: begin b = malt; malt = ~malt; end
                    default: b = 1'b1;
                endcase
                exp_b = b ^ mpend;
                mpend = 1'b0;
            end
        end
        if (inj) mpend = 1'b1;
        @(posedge clk);
        #2;
        check(req, tx_valid, tx_bit, en, exp_b);
        bit_en = 1'b0; err_inject = 1'b0;
    endtask

    initial begin
        #(8ns * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        check("R1", tx_valid, tx_bit, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #2;
        check("R1", tx_valid, tx_bit, 1'b0, 1'b0);

        // R4: 15-stage sequence straight from the seed, idle gaps for R12 / R2
        for (int i = 0; i < 300; i++) begin
            if (i % 7 == 6) apply(1'b0, 1'b0, 1'b0, 2'd0, "R12");
            apply(1'b1, 1'b0, 1'b0, 2'd0, "R4");
        end
        // R5 and R11: switch to 20-stage, restart from the seed
        for (int i = 0; i < 400; i++) begin
            if (i % 11 == 5) apply(1'b0, 1'b1, 1'b0, 2'd1, "R2");
            apply(1'b1, 1'b0, 1'b0, 2'd1, "R5");
        end
        for (int i = 0; i < 24; i++) apply(1'b1, 1'b0, 1'b0, 2'd2, "R6");
        for (int i = 0; i < 24; i++) apply(1'b1, 1'b0, 1'b0, 2'd3, "R7");

        // R9: the slot strobe toggles with framing off
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 40; i++) apply(1'b1, i[0], 1'b0, 2'(p), "R9");
        end

        // R8: sparse payload map with framing on
        set_framed(1'b1);
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 80; i++) apply(1'b1, (i % 5) != 0, 1'b0, 2'(p), "R8");
        end

        // R10: requests on payload bits, on overhead bits, during idle, back to back
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < 60; i++) begin
                if (i % 9 == 3) apply(1'b0, 1'b0, 1'b1, 2'(p), "R10");
                apply(1'b1, (i % 3) != 0, (i % 13 == 0) || (i % 13 == 1), 2'(p), "R10");
            end
        end
        set_framed(1'b0);
        for (int i = 0; i < 40; i++) apply(1'b1, 1'b0, (i % 6 == 2), 2'd0, "R10");

        // R11 and R3: flip the selection back and forth
        for (int k = 0; k < 12; k++) begin
            for (int i = 0; i < 10 + k; i++) apply(1'b1, 1'b0, 1'b0, 2'(k % 4), "R11");
            for (int i = 0; i < 8; i++) apply(1'b1, 1'b0, 1'b0, 2'((k + 1) % 4), "R3");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule